// File: doc/BRIEF.md
# Indexed-Colour Display Controller Register File

This block is the control and storage side of an 8-bit indexed-colour display controller. It sits on a 32-bit register bus with a 21-bit byte offset. It holds three tables: a colour lookup table of packed RGB entries, a small cursor colour table, and a two-bit-per-pixel cursor shape. It also holds the scalar settings a scan-out engine needs: control word, display width and height, frame-store start offset and cursor position. All of these are presented continuously on output ports. Each table also has its own lookup port for the pixel pipeline.

Software may access any register with byte, halfword or word accesses. A narrow write is turned into a whole-word write: the current value of the word is read, the addressed lanes are replaced, and the merged word goes through the same path as a full write. This includes the scaling applied to the width and height registers. A write to the timing area is accepted and has no effect. A write to a dedicated offset returns every table and setting to zero. A frame-complete pulse from the scan-out logic raises the interrupt line, and any register write lowers it.

Top module: `fbctl_regfile`

## Requirements
- R1: After reset every table entry, the control word, width, height, start offset and cursor position are zero. Reads of them return zero, `irq` and `rsp_valid` are low, and `depth_bits` shows 1 (the decoding of code 0).
- R2: The colour table lives at offsets 0x800 to 0xFFF with one entry per 8 bytes. Bits 23:16 are red, 15:8 green and 7:0 blue, and bits 31:24 read as zero. `pal_lk_rgb` returns the entry selected by `pal_lk_idx`.
- R3: The cursor colour table holds three 24-bit entries at 0x400, 0x408 and 0x410, packed like R2. The cursor shape holds 512 16-bit entries at 0x1000 to 0x1FFF, 8 bytes apart, and its bits 31:16 read as zero. Both are readable, and a cursor colour lookup with index 3 returns zero.
- R4: A write of v to the width register (0x108) sets `active_width` to 4*v, truncated to DIM_W bits. A read of that register returns `active_width`/4.
- R5: A write of v to the height register (0x110) sets `active_height` to v/2, rounded down. A read returns `active_height`*2, so an odd value reads back one lower.
- R6: In the control word (0x100), bit 10 drives `blank_force` and bit 23 drives `cursor_hide`. Bits 22:20 select `depth_bits`: codes 0 to 5 give 1, 2, 4, 8, 15 and 16, and codes 6 and 7 give 0. The whole word reads back.
- R7: The identifier at 0x000 reads 0x10 and writes to it are discarded. The timing area 0x200 to 0x3FF accepts writes, discards them and reads zero. Reads of any other unmapped offset return zero.
- R8: A byte write (size 0) with address bits 1:0 = n replaces bits 8n+7:8n of the addressed word with `req_wdata[7:0]` and keeps the other bits.
- R9: A halfword write (size 1) replaces bits 31:16 when address bit 1 is set and bits 15:0 otherwise, using `req_wdata[15:0]`. Byte and halfword reads return the same lanes, right-aligned and zero-extended. Sizes 2 and 3 are word accesses.
- R10: A write to offset 0x100000 clears every table entry, the control word, width, height, start offset and cursor position. The identifier is unchanged.
- R11: A `frame_done` pulse sets `irq` on the next edge. Any accepted write clears it. When both happen in the same cycle, `irq` is set.
- R12: `req_ready` is always high. An accepted read gives `rsp_valid` high on the next cycle with `rsp_rdata`, and `rsp_valid` is low in every other cycle.
- R13: The start offset (0x118) is a full 32-bit register on `screen_base`. The cursor position (0x120) keeps bits 23:0, with X in bits 23:12 on `cursor_x` and Y in bits 11:0 on `cursor_y`. Bits 31:24 are discarded and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Request accepted (constant high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_addr | input | 21 | Byte offset |
| req_wdata | input | 32 | Write data, narrow data right-aligned |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Registered read data |
| frame_done | input | 1 | One-cycle frame-complete pulse |
| irq | output | 1 | Frame interrupt |
| depth_bits | output | 5 | Decoded bits per pixel |
| blank_force | output | 1 | Force display blank |
| cursor_hide | output | 1 | Cursor disabled |
| active_width | output | 16 | Visible width in pixels |
| active_height | output | 16 | Visible height in lines |
| screen_base | output | 32 | Frame-store start offset |
| cursor_x | output | 12 | Cursor X |
| cursor_y | output | 12 | Cursor Y |
| pal_lk_idx | input | 8 | Colour table lookup index |
| pal_lk_rgb | output | 24 | Colour table lookup result |
| cpal_lk_idx | input | 2 | Cursor colour lookup index |
| cpal_lk_rgb | output | 24 | Cursor colour lookup result |
| cpat_lk_idx | input | 9 | Cursor shape lookup index |
| cpat_lk_bits | output | 16 | Cursor shape lookup result |

## Verification
The bound checker watches the bus timing and the interrupt rules on every cycle. That covers the one-cycle read response, set-over-clear priority and holding when idle. It also checks that the depth output only takes legal values, that the identifier always reads 0x10, that a full write to the width register lands scaled, and that the reset offset zeroes the scalar outputs.

Lane merging on every register kind, the lossy rounding of odd heights, discarded writes to the identifier and timing area, and table contents seen through both bus and lookup ports can only be shown by the bench's sequences. The same holds for the full clearing of the tables by the reset offset.

// File: rtl/fbctl_pkg.sv
`timescale 1ns/1ps
package fbctl_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WALT = 2'd3
   } acc_size_e;

   typedef enum logic [3:0] {
      RG_NONE, RG_ID, RG_CTRL, RG_HDISP, RG_VDISP, RG_BASE, RG_CPOS,
      RG_TIMING, RG_CPAL, RG_PAL, RG_CPAT, RG_RESET
   } region_e;

   // byte offsets of the register map
   localparam int unsigned OFS_ID      = 32'h0000_0000;
   localparam int unsigned OFS_CTRL    = 32'h0000_0100;
   localparam int unsigned OFS_HDISP   = 32'h0000_0108;
   localparam int unsigned OFS_VDISP   = 32'h0000_0110;
   localparam int unsigned OFS_BASE    = 32'h0000_0118;
   localparam int unsigned OFS_CPOS    = 32'h0000_0120;
   localparam int unsigned OFS_TIM_LO  = 32'h0000_0200;
   localparam int unsigned OFS_TIM_HI  = 32'h0000_0400;
   localparam int unsigned OFS_CPAL    = 32'h0000_0400;
   localparam int unsigned OFS_PAL     = 32'h0000_0800;
   localparam int unsigned OFS_CPAT    = 32'h0000_1000;
   localparam int unsigned OFS_RESET   = 32'h0010_0000;
   localparam int unsigned ENTRY_SHIFT = 3;

   // control word fields
   localparam int unsigned CTL_BLANK_BIT = 10;
   localparam int unsigned CTL_DEPTH_LSB = 20;
   localparam int unsigned CTL_HIDE_BIT  = 23;

   function automatic logic [4:0] depth_of(input logic [2:0] code);
      logic [4:0] d;
      case (code)
         3'd0:    d = 5'd1;
         3'd1:    d = 5'd2;
         3'd2:    d = 5'd4;
         3'd3:    d = 5'd8;
         3'd4:    d = 5'd15;
         3'd5:    d = 5'd16;
         default: d = 5'd0;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/fbctl_decode.sv
`timescale 1ns/1ps
module fbctl_decode
   import fbctl_pkg::*;
#(
   parameter int ADDR_W     = 21,
   parameter int PAL_DEPTH  = 256,
   parameter int CPAL_DEPTH = 3,
   parameter int CPAT_DEPTH = 512,
   localparam int PAL_IW    = $clog2(PAL_DEPTH),
   localparam int CPAL_IW   = $clog2(CPAL_DEPTH),
   localparam int CPAT_IW   = $clog2(CPAT_DEPTH)
) (
   input  logic [ADDR_W-1:0]  addr,
   output region_e            region,
   output logic [PAL_IW-1:0]  pal_idx,
   output logic [CPAL_IW-1:0] cpal_idx,
   output logic [CPAT_IW-1:0] cpat_idx
);
   localparam logic [ADDR_W-1:0] A_ID    = ADDR_W'(OFS_ID);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_HDISP = ADDR_W'(OFS_HDISP);
   localparam logic [ADDR_W-1:0] A_VDISP = ADDR_W'(OFS_VDISP);
   localparam logic [ADDR_W-1:0] A_BASE  = ADDR_W'(OFS_BASE);
   localparam logic [ADDR_W-1:0] A_CPOS  = ADDR_W'(OFS_CPOS);
   localparam logic [ADDR_W-1:0] A_RESET = ADDR_W'(OFS_RESET);
   localparam logic [ADDR_W-1:0] T_LO    = ADDR_W'(OFS_TIM_LO);
   localparam logic [ADDR_W-1:0] T_HI    = ADDR_W'(OFS_TIM_HI);
   localparam logic [ADDR_W-1:0] CP_LO   = ADDR_W'(OFS_CPAL);
   localparam logic [ADDR_W-1:0] CP_HI   = ADDR_W'(OFS_CPAL + (CPAL_DEPTH << ENTRY_SHIFT));
   localparam logic [ADDR_W-1:0] P_LO    = ADDR_W'(OFS_PAL);
   localparam logic [ADDR_W-1:0] P_HI    = ADDR_W'(OFS_PAL + (PAL_DEPTH << ENTRY_SHIFT));
   localparam logic [ADDR_W-1:0] S_LO    = ADDR_W'(OFS_CPAT);
   localparam logic [ADDR_W-1:0] S_HI    = ADDR_W'(OFS_CPAT + (CPAT_DEPTH << ENTRY_SHIFT));

   logic [ADDR_W-1:0] word_a;
   logic [ADDR_W-1:0] rel_cp, rel_p, rel_s;

   assign word_a = {addr[ADDR_W-1:2], 2'b00};
   assign rel_cp = addr - CP_LO;
   assign rel_p  = addr - P_LO;
   assign rel_s  = addr - S_LO;

   assign cpal_idx = rel_cp[ENTRY_SHIFT +: CPAL_IW];
   assign pal_idx  = rel_p[ENTRY_SHIFT +: PAL_IW];
   assign cpat_idx = rel_s[ENTRY_SHIFT +: CPAT_IW];

   always_comb begin
      if (addr >= P_LO && addr < P_HI)        region = RG_PAL;
      else if (addr >= S_LO && addr < S_HI)   region = RG_CPAT;
      else if (addr >= CP_LO && addr < CP_HI) region = RG_CPAL;
      else if (addr >= T_LO && addr < T_HI)   region = RG_TIMING;
      else if (word_a == A_ID)                region = RG_ID;
      else if (word_a == A_CTRL)              region = RG_CTRL;
      else if (word_a == A_HDISP)             region = RG_HDISP;
      else if (word_a == A_VDISP)             region = RG_VDISP;
      else if (word_a == A_BASE)              region = RG_BASE;
      else if (word_a == A_CPOS)              region = RG_CPOS;
      else if (word_a == A_RESET)             region = RG_RESET;
      else                                    region = RG_NONE;
   end

endmodule

// File: rtl/fbctl_lane_merge.sv
`timescale 1ns/1ps
module fbctl_lane_merge
   import fbctl_pkg::*;
(
   input  acc_size_e   size,
   input  logic [1:0]  lane,
   input  logic [31:0] cur_word,
   input  logic [31:0] wdata,
   output logic [31:0] merged,
   output logic [31:0] rd_lanes
);
   localparam int LANES = 4;

   logic [31:0] src;
   logic [31:0] shifted;

   always_comb begin
      case (size)
         SZ_BYTE: src = {4{wdata[7:0]}};
         SZ_HALF: src = {2{wdata[15:0]}};
         default: src = wdata;
      endcase
   end

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      logic take;
      assign take = (size == SZ_BYTE) ? (lane == 2'(b)) :
                    (size == SZ_HALF) ? (lane[1] == 1'(b / 2)) : 1'b1;
      assign merged[8*b +: 8] = take ? src[8*b +: 8] : cur_word[8*b +: 8];
   end

   assign shifted = cur_word >> {lane, 3'b000};

   always_comb begin
      case (size)
         SZ_BYTE: rd_lanes = {24'h0, shifted[7:0]};
         SZ_HALF: rd_lanes = {16'h0, lane[1] ? cur_word[31:16] : cur_word[15:0]};
         default: rd_lanes = cur_word;
      endcase
   end

endmodule

// File: rtl/fbctl_store.sv
`timescale 1ns/1ps
module fbctl_store #(
   parameter int DEPTH = 256,
   parameter int W     = 24,
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          we,
   input  logic [IW-1:0] idx,
   input  logic [W-1:0]  wdata,
   output logic [W-1:0]  rdata,
   input  logic [IW-1:0] lk_idx,
   output logic [W-1:0]  lk_data
);
   localparam logic [IW:0] DEPTH_L = (IW+1)'(DEPTH);

   logic [W-1:0] mem [DEPTH];
   logic         idx_ok, lk_ok;

   assign idx_ok = ({1'b0, idx} < DEPTH_L);
   assign lk_ok  = ({1'b0, lk_idx} < DEPTH_L);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (clr) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we && idx_ok) begin
         mem[idx] <= wdata;
      end
   end

   assign rdata   = idx_ok ? mem[idx] : '0;
   assign lk_data = lk_ok ? mem[lk_idx] : '0;

endmodule

// File: rtl/fbctl_regfile.sv
`timescale 1ns/1ps
module fbctl_regfile
   import fbctl_pkg::*;
#(
   parameter int          ADDR_W     = 21,
   parameter int          CHAN_W     = 8,
   parameter int          PAL_DEPTH  = 256,
   parameter int          CPAL_DEPTH = 3,
   parameter int          CPAT_DEPTH = 512,
   parameter int          CPAT_W     = 16,
   parameter int          DIM_W      = 16,
   parameter int          COORD_W    = 12,
   parameter logic [31:0] ID_VALUE   = 32'h0000_0010,
   localparam int RGB_W   = 3 * CHAN_W,
   localparam int PAL_IW  = $clog2(PAL_DEPTH),
   localparam int CPAL_IW = $clog2(CPAL_DEPTH),
   localparam int CPAT_IW = $clog2(CPAT_DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic               req_write,
   input  logic [1:0]         req_size,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [31:0]        req_wdata,
   output logic               rsp_valid,
   output logic [31:0]        rsp_rdata,
   input  logic               frame_done,
   output logic               irq,
   output logic [4:0]         depth_bits,
   output logic               blank_force,
   output logic               cursor_hide,
   output logic [DIM_W-1:0]   active_width,
   output logic [DIM_W-1:0]   active_height,
   output logic [31:0]        screen_base,
   output logic [COORD_W-1:0] cursor_x,
   output logic [COORD_W-1:0] cursor_y,
   input  logic [PAL_IW-1:0]  pal_lk_idx,
   output logic [RGB_W-1:0]   pal_lk_rgb,
   input  logic [CPAL_IW-1:0] cpal_lk_idx,
   output logic [RGB_W-1:0]   cpal_lk_rgb,
   input  logic [CPAT_IW-1:0] cpat_lk_idx,
   output logic [CPAT_W-1:0]  cpat_lk_bits
);
   localparam int CPOS_W = 2 * COORD_W;

   initial begin : elab_checks
      assert (ADDR_W >= 21) else $fatal(1, "ADDR_W too small for the map");
      assert (RGB_W <= 32) else $fatal(1, "CHAN_W too wide");
      assert (CPAT_W <= 32) else $fatal(1, "CPAT_W too wide");
      assert (DIM_W >= 4 && DIM_W <= 31) else $fatal(1, "DIM_W out of range");
      assert (CPOS_W <= 32) else $fatal(1, "COORD_W too wide");
      assert ((PAL_DEPTH << ENTRY_SHIFT) <= int'(OFS_CPAT - OFS_PAL))
         else $fatal(1, "colour table overflows its window");
      assert ((CPAL_DEPTH << ENTRY_SHIFT) <= int'(OFS_PAL - OFS_CPAL))
         else $fatal(1, "cursor colour table overflows its window");
      assert ((CPAT_DEPTH << ENTRY_SHIFT) <= 'h1000)
         else $fatal(1, "cursor shape overflows its window");
      assert (CPAL_DEPTH >= 2 && PAL_DEPTH >= 2 && CPAT_DEPTH >= 2)
         else $fatal(1, "table depths must be at least 2");
   end

   region_e             region;
   logic [PAL_IW-1:0]   pal_idx;
   logic [CPAL_IW-1:0]  cpal_idx;
   logic [CPAT_IW-1:0]  cpat_idx;
   logic                acc, wr_go, rd_go, clr_all;
   logic [31:0]         cur_word, merged, rd_lanes;
   logic [RGB_W-1:0]    pal_rd, cpal_rd;
   logic [CPAT_W-1:0]   cpat_rd;

   logic [31:0]         ctrl_q;
   logic [DIM_W-1:0]    width_q, height_q;
   logic [31:0]         base_q;
   logic [CPOS_W-1:0]   cpos_q;

   assign req_ready = 1'b1;
   assign acc       = req_valid && req_ready;
   assign wr_go     = acc && req_write;
   assign rd_go     = acc && !req_write;
   assign clr_all   = wr_go && (region == RG_RESET);

   fbctl_decode #(
      .ADDR_W(ADDR_W), .PAL_DEPTH(PAL_DEPTH),
      .CPAL_DEPTH(CPAL_DEPTH), .CPAT_DEPTH(CPAT_DEPTH)
   ) u_decode (
      .addr(req_addr), .region(region),
      .pal_idx(pal_idx), .cpal_idx(cpal_idx), .cpat_idx(cpat_idx)
   );

   fbctl_store #(.DEPTH(PAL_DEPTH), .W(RGB_W)) u_pal (
      .clk(clk), .rst_n(rst_n), .clr(clr_all),
      .we(wr_go && region == RG_PAL), .idx(pal_idx), .wdata(merged[RGB_W-1:0]),
      .rdata(pal_rd), .lk_idx(pal_lk_idx), .lk_data(pal_lk_rgb)
   );

   fbctl_store #(.DEPTH(CPAL_DEPTH), .W(RGB_W)) u_cpal (
      .clk(clk), .rst_n(rst_n), .clr(clr_all),
      .we(wr_go && region == RG_CPAL), .idx(cpal_idx), .wdata(merged[RGB_W-1:0]),
      .rdata(cpal_rd), .lk_idx(cpal_lk_idx), .lk_data(cpal_lk_rgb)
   );

   fbctl_store #(.DEPTH(CPAT_DEPTH), .W(CPAT_W)) u_cpat (
      .clk(clk), .rst_n(rst_n), .clr(clr_all),
      .we(wr_go && region == RG_CPAT), .idx(cpat_idx), .wdata(merged[CPAT_W-1:0]),
      .rdata(cpat_rd), .lk_idx(cpat_lk_idx), .lk_data(cpat_lk_bits)
   );

   // current architectural value of the addressed word, as software sees it
   always_comb begin
      case (region)
         RG_ID:    cur_word = ID_VALUE;
         RG_CTRL:  cur_word = ctrl_q;
         RG_HDISP: cur_word = 32'(width_q >> 2);
         RG_VDISP: cur_word = 32'({height_q, 1'b0});
         RG_BASE:  cur_word = base_q;
         RG_CPOS:  cur_word = 32'(cpos_q);
         RG_CPAL:  cur_word = 32'(cpal_rd);
         RG_PAL:   cur_word = 32'(pal_rd);
         RG_CPAT:  cur_word = 32'(cpat_rd);
         default:  cur_word = 32'h0;
      endcase
   end

   fbctl_lane_merge u_merge (
      .size(acc_size_e'(req_size)), .lane(req_addr[1:0]),
      .cur_word(cur_word), .wdata(req_wdata),
      .merged(merged), .rd_lanes(rd_lanes)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         width_q  <= '0;
         height_q <= '0;
         base_q   <= '0;
         cpos_q   <= '0;
      end else if (wr_go) begin
         case (region)
            RG_CTRL:  ctrl_q   <= merged;
            RG_HDISP: width_q  <= {merged[DIM_W-3:0], 2'b00};
            RG_VDISP: height_q <= merged[DIM_W:1];
            RG_BASE:  base_q   <= merged;
            RG_CPOS:  cpos_q   <= merged[CPOS_W-1:0];
            RG_RESET: begin
               ctrl_q   <= '0;
               width_q  <= '0;
               height_q <= '0;
               base_q   <= '0;
               cpos_q   <= '0;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= rd_go;
         if (rd_go) rsp_rdata <= rd_lanes;
      end
   end

   // a completed frame outranks a clearing write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          irq <= 1'b0;
      else if (frame_done) irq <= 1'b1;
      else if (wr_go)      irq <= 1'b0;
   end

   assign depth_bits    = depth_of(ctrl_q[CTL_DEPTH_LSB +: 3]);
   assign blank_force   = ctrl_q[CTL_BLANK_BIT];
   assign cursor_hide   = ctrl_q[CTL_HIDE_BIT];
   assign active_width  = width_q;
   assign active_height = height_q;
   assign screen_base   = base_q;
   assign cursor_x      = cpos_q[CPOS_W-1:COORD_W];
   assign cursor_y      = cpos_q[COORD_W-1:0];

endmodule

// File: rtl/fbctl_regfile_chk.sv
`timescale 1ns/1ps
module fbctl_regfile_chk
   import fbctl_pkg::*;
#(
   parameter int          ADDR_W   = 21,
   parameter int          DIM_W    = 16,
   parameter int          COORD_W  = 12,
   parameter logic [31:0] ID_VALUE = 32'h0000_0010
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_write,
   input logic [1:0]         req_size,
   input logic [ADDR_W-1:0]  req_addr,
   input logic [31:0]        req_wdata,
   input logic               rsp_valid,
   input logic [31:0]        rsp_rdata,
   input logic               frame_done,
   input logic               irq,
   input logic [4:0]         depth_bits,
   input logic [DIM_W-1:0]   active_width,
   input logic [DIM_W-1:0]   active_height,
   input logic [31:0]        screen_base,
   input logic [COORD_W-1:0] cursor_x,
   input logic [COORD_W-1:0] cursor_y
);
   localparam logic [ADDR_W-1:0] A_ID    = ADDR_W'(OFS_ID);
   localparam logic [ADDR_W-1:0] A_HDISP = ADDR_W'(OFS_HDISP);
   localparam logic [ADDR_W-1:0] A_RESET = ADDR_W'(OFS_RESET);

   logic is_rd, is_wr, hit_id, hit_hdisp, hit_reset;
   assign is_rd     = req_valid && !req_write;
   assign is_wr     = req_valid && req_write;
   assign hit_id    = req_addr[ADDR_W-1:2] == A_ID[ADDR_W-1:2];
   assign hit_hdisp = req_addr[ADDR_W-1:2] == A_HDISP[ADDR_W-1:2];
   assign hit_reset = req_addr[ADDR_W-1:2] == A_RESET[ADDR_W-1:2];

   // R12
   rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_rd |=> rsp_valid);
   // R12
   no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !is_rd |=> !rsp_valid);
   // R11
   irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> irq);
   // R11
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && !frame_done) |=> !irq);
   // R11
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_wr && !frame_done) |=> $stable(irq));
   // R6
   depth_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      depth_bits inside {5'd0, 5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16});
   // R7
   id_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_rd && req_size == 2'd2 && hit_id) |=> rsp_rdata == ID_VALUE);
   // R4
   width_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && req_size == 2'd2 && hit_hdisp) |=>
         active_width == {$past(req_wdata[DIM_W-3:0]), 2'b00});
   // R10
   reset_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_wr && hit_reset) |=> (active_width == '0 && active_height == '0 &&
         screen_base == '0 && cursor_x == '0 && cursor_y == '0));

endmodule

bind fbctl_regfile fbctl_regfile_chk #(
   .ADDR_W(ADDR_W), .DIM_W(DIM_W), .COORD_W(COORD_W), .ID_VALUE(ID_VALUE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
   .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .frame_done(frame_done),
   .irq(irq), .depth_bits(depth_bits), .active_width(active_width),
   .active_height(active_height), .screen_base(screen_base),
   .cursor_x(cursor_x), .cursor_y(cursor_y)
);

// File: tb/tb_fbctl_regfile.sv
`timescale 1ns/1ps
module tb_fbctl_regfile;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]  req_size = 2'd2;
   logic [20:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        req_ready, rsp_valid, irq, blank_force, cursor_hide;
   logic [31:0] rsp_rdata, screen_base;
   logic        frame_done = 1'b0;
   logic [4:0]  depth_bits;
   logic [15:0] active_width, active_height;
   logic [11:0] cursor_x, cursor_y;
   logic [7:0]  pal_lk_idx = '0;
   logic [23:0] pal_lk_rgb, cpal_lk_rgb;
   logic [1:0]  cpal_lk_idx = '0;
   logic [8:0]  cpat_lk_idx = '0;
   logic [15:0] cpat_lk_bits;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   fbctl_regfile dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
      .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .frame_done(frame_done), .irq(irq), .depth_bits(depth_bits),
      .blank_force(blank_force), .cursor_hide(cursor_hide),
      .active_width(active_width), .active_height(active_height),
      .screen_base(screen_base), .cursor_x(cursor_x), .cursor_y(cursor_y),
      .pal_lk_idx(pal_lk_idx), .pal_lk_rgb(pal_lk_rgb),
      .cpal_lk_idx(cpal_lk_idx), .cpal_lk_rgb(cpal_lk_rgb),
      .cpat_lk_idx(cpat_lk_idx), .cpat_lk_bits(cpat_lk_bits)
   );

   localparam logic [1:0] B = 2'd0, H = 2'd1, W = 2'd2;
   localparam int NV = 32;
   // {req[3:0], write, size[1:0], addr[20:0], wdata[31:0], expected[31:0]}
   localparam logic [91:0] VEC [NV] = '{
      {4'd2, 1'b1, W, 21'h000800, 32'hAA112233, 32'h0},        // R2
      {4'd2, 1'b0, W, 21'h000800, 32'h0, 32'h00112233},
      {4'd2, 1'b1, W, 21'h000FF8, 32'h00ABCDEF, 32'h0},
      {4'd2, 1'b0, W, 21'h000FF8, 32'h0, 32'h00ABCDEF},
      {4'd2, 1'b0, W, 21'h000808, 32'h0, 32'h0},
      {4'd3, 1'b1, W, 21'h000410, 32'h00102030, 32'h0},        // R3
      {4'd3, 1'b0, W, 21'h000410, 32'h0, 32'h00102030},
      {4'd3, 1'b1, W, 21'h001FF8, 32'h1234BEEF, 32'h0},
      {4'd3, 1'b0, W, 21'h001FF8, 32'h0, 32'h0000BEEF},
      {4'd4, 1'b1, W, 21'h000108, 32'h140, 32'h0},             // R4
      {4'd4, 1'b0, W, 21'h000108, 32'h0, 32'h140},
      {4'd5, 1'b1, W, 21'h000110, 32'h1E1, 32'h0},             // R5
      {4'd5, 1'b0, W, 21'h000110, 32'h0, 32'h1E0},
      {4'd7, 1'b1, W, 21'h000000, 32'h55, 32'h0},              // R7
      {4'd7, 1'b0, W, 21'h000000, 32'h0, 32'h10},
      {4'd7, 1'b1, W, 21'h000200, 32'hFFFF, 32'h0},
      {4'd7, 1'b0, W, 21'h000200, 32'h0, 32'h0},
      {4'd7, 1'b0, W, 21'h000500, 32'h0, 32'h0},
      {4'd8, 1'b1, W, 21'h000118, 32'h11223344, 32'h0},        // R8
      {4'd8, 1'b1, B, 21'h00011A, 32'hEE, 32'h0},
      {4'd8, 1'b0, W, 21'h000118, 32'h0, 32'h11EE3344},
      {4'd9, 1'b0, B, 21'h00011B, 32'h0, 32'h11},              // R9
      {4'd9, 1'b0, H, 21'h00011A, 32'h0, 32'h11EE},
      {4'd9, 1'b1, H, 21'h000118, 32'hCAFE, 32'h0},
      {4'd9, 1'b0, W, 21'h000118, 32'h0, 32'h11EECAFE},
      {4'd9, 1'b1, H, 21'h000122, 32'h0005, 32'h0},
      {4'd9, 1'b0, W, 21'h000120, 32'h0, 32'h00050000},
      {4'd8, 1'b1, B, 21'h000801, 32'h77, 32'h0},
      {4'd8, 1'b0, W, 21'h000800, 32'h0, 32'h00117733},
      {4'd8, 1'b1, B, 21'h000108, 32'h10, 32'h0},
      {4'd8, 1'b0, W, 21'h000108, 32'h0, 32'h110},
      {4'd9, 1'b0, B, 21'h000800, 32'h0, 32'h33}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [1:0] sz, input logic [20:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_size = sz; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] sz, input logic [20:0] a, output logic [31:0] d,
                           output logic v);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_size = sz; req_addr = a; req_wdata = '0;
      @(negedge clk);
      req_valid = 1'b0;
      d = rsp_rdata;
      v = rsp_valid;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin : watchdog
      #(5.0 * 100000);
      n_chk++;
      n_err++;
      $display("FAIL R12 watchdog expired actual=%h expected=%h", 1'b0, 1'b1);
      finish_run();
   end

   initial begin : main
      logic [31:0] rd;
      logic        rv;
      logic [4:0]  depth_exp [8];
      depth_exp = '{5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16, 5'd0, 5'd0};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check("R1 irq", 32'(irq), 32'h0);
      check("R1 rsp_valid", 32'(rsp_valid), 32'h0);
      check("R1 depth", 32'(depth_bits), 32'd1);
      check("R1 width", 32'(active_width), 32'h0);
      bus_read(W, 21'h000100, rd, rv);
      check("R1 ctrl read", rd, 32'h0);
      bus_read(W, 21'h000838, rd, rv);
      check("R1 palette entry 7", rd, 32'h0);
      bus_read(W, 21'h000000, rd, rv);
      check("R1 identifier", rd, 32'h10);

      // R12: handshake
      check("R12 ready", 32'(req_ready), 32'h1);
      check("R12 read response valid", 32'(rv), 32'h1);
      bus_write(W, 21'h000200, 32'h1);
      check("R12 no response after write", 32'(rsp_valid), 32'h0);

      // table walk: R2 R3 R4 R5 R7 R8 R9
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][87]) begin
            bus_write(VEC[i][86:85], VEC[i][84:64], VEC[i][63:32]);
         end else begin
            bus_read(VEC[i][86:85], VEC[i][84:64], rd, rv);
            check($sformatf("R%0d vector %0d", VEC[i][91:88], i), rd, VEC[i][31:0]);
         end
      end

      check("R4 active width", 32'(active_width), 32'h440);
      check("R5 active height", 32'(active_height), 32'd240);
      check("R13 screen base", screen_base, 32'h11EECAFE);
      check("R13 cursor x", 32'(cursor_x), 32'h50);
      check("R13 cursor y", 32'(cursor_y), 32'h0);

      // R13: position keeps 24 bits
      bus_write(W, 21'h000120, 32'hFFABC123);
      check("R13 cursor x full", 32'(cursor_x), 32'hABC);
      check("R13 cursor y full", 32'(cursor_y), 32'h123);
      bus_read(W, 21'h000120, rd, rv);
      check("R13 position readback", rd, 32'h00ABC123);

      // R2 R3: lookup ports
      pal_lk_idx = 8'd255; cpal_lk_idx = 2'd2; cpat_lk_idx = 9'd511;
      #1;
      check("R2 lookup 255", 32'(pal_lk_rgb), 32'hABCDEF);
      check("R3 cursor colour lookup 2", 32'(cpal_lk_rgb), 32'h102030);
      check("R3 shape lookup 511", 32'(cpat_lk_bits), 32'hBEEF);
      cpal_lk_idx = 2'd3;
      #1;
      check("R3 cursor colour lookup 3", 32'(cpal_lk_rgb), 32'h0);

      // R6: control word decoding
      bus_write(W, 21'h000100, 32'h00B00400);
      check("R6 blank", 32'(blank_force), 32'h1);
      check("R6 hide", 32'(cursor_hide), 32'h1);
      check("R6 depth code 3", 32'(depth_bits), 32'd8);
      bus_read(W, 21'h000100, rd, rv);
      check("R6 ctrl readback", rd, 32'h00B00400);
      for (int c = 0; c < 8; c++) begin
         bus_write(W, 21'h000100, 32'(c) << 20);
         check($sformatf("R6 depth code %0d", c), 32'(depth_bits), 32'(depth_exp[c]));
      end
      check("R6 blank cleared", 32'(blank_force), 32'h0);

      // R11: interrupt
      @(negedge clk); frame_done = 1'b1;
      @(negedge clk); frame_done = 1'b0;
      check("R11 set by frame_done", 32'(irq), 32'h1);
      bus_read(W, 21'h000000, rd, rv);
      check("R11 read keeps irq", 32'(irq), 32'h1);
      bus_write(W, 21'h000000, 32'h0);
      check("R11 write clears", 32'(irq), 32'h0);
      @(negedge clk);
      frame_done = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_size = W;
      req_addr = 21'h000200; req_wdata = '0;
      @(negedge clk);
      frame_done = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      check("R11 frame_done wins", 32'(irq), 32'h1);

      // R10: reset offset
      bus_write(W, 21'h000100, 32'h00300400);
      bus_write(W, 21'h100000, 32'h0);
      check("R10 width", 32'(active_width), 32'h0);
      check("R10 height", 32'(active_height), 32'h0);
      check("R10 base", screen_base, 32'h0);
      check("R10 blank", 32'(blank_force), 32'h0);
      check("R10 depth", 32'(depth_bits), 32'd1);
      bus_read(W, 21'h000FF8, rd, rv);
      check("R10 palette cleared", rd, 32'h0);
      bus_read(W, 21'h000410, rd, rv);
      check("R10 cursor colour cleared", rd, 32'h0);
      bus_read(W, 21'h001FF8, rd, rv);
      check("R10 shape cleared", rd, 32'h0);
      bus_read(W, 21'h000120, rd, rv);
      check("R10 position cleared", rd, 32'h0);
      bus_read(W, 21'h000000, rd, rv);
      check("R10 identifier kept", rd, 32'h10);
      pal_lk_idx = 8'd0;
      #1;
      check("R10 lookup cleared", 32'(pal_lk_rgb), 32'h0);

      finish_run();
   end

endmodule